// File: doc/BRIEF.md
# Pipeline Hazard Resolution Unit

This block is the combinational hazard controller of a five-stage in-order pipeline. Stage 1 is fetch, stage 2 decode, stage 3 execute, stage 4 memory and stage 5 write-back. In the same cycle it produces three kinds of decision:

- **Forwarding.** For each ALU operand in stage 3 it chooses where the value comes from: the register file path, the result held in stage 4, or the result held in stage 5.
- **Load-use stall.** When a load sitting in stage 3 targets a register that the instruction in decode is about to read, it holds the program counter and the fetch/decode register.
- **Flush.** When a branch is taken or a jump resolves in stage 4, it clears the pipeline registers of stages 1 to 3.

All outputs depend only on the current inputs. There are no registers in the block. The surrounding datapath applies the selects and enables at its own clock edge.

Top module: `hz_resolve_unit`

## Requirements
- R1: Each forwarding select is a 2-bit code: 2'd0 keeps the normal operand path, 2'd1 takes the stage-4 result and 2'd2 takes the stage-5 result. Code 2'd3 never appears.
- R2: `fwd_a_sel` is 2'd1 whenever `s4_wen` is 1, `s4_dst` is nonzero and `s4_dst` equals `s3_rs`.
- R3: The stage-4 match has priority over the stage-5 match. `fwd_a_sel` is 2'd2 only when the R2 condition is false, `s5_wen` is 1, `s5_dst` is nonzero and `s5_dst` equals `s3_rs`. If both stages match, the code is 2'd1. Otherwise the code is 2'd0.
- R4: `fwd_b_sel` follows the rules of R2 and R3, comparing against `s3_rt` in place of `s3_rs`.
- R5: A destination address of zero never causes forwarding, whatever the write enable and source addresses.
- R6: `hold_fetch` is 1 when all three of these hold:
  - `s3_memrd` is 1;
  - `s3_rt` equals `s2_rs` or `s2_rt`;
  - no flush is requested.
- R7: `hold_fetch` is 0 when `s3_memrd` is 0, or when `s3_rt` matches neither `s2_rs` nor `s2_rt`.
- R8: `flush_o` bit 0, 1 and 2 clear the pipeline registers of stages 1, 2 and 3. All three bits are 1 when `br_taken` or `s4_jump` is 1, and all are 0 when both are 0.
- R9: When a flush and a load-use match occur in the same cycle, the flush wins: `flush_o` is all ones and `hold_fetch` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| s4_wen | input | 1 | Register write enable of the stage-4 instruction |
| s4_dst | input | 5 | Destination register of the stage-4 instruction |
| s5_wen | input | 1 | Register write enable of the stage-5 instruction |
| s5_dst | input | 5 | Destination register of the stage-5 instruction |
| s3_rs | input | 5 | First source register of the stage-3 instruction |
| s3_rt | input | 5 | Second source / load target register of the stage-3 instruction |
| s3_memrd | input | 1 | Stage-3 instruction reads memory |
| s2_rs | input | 5 | First source register of the decode-stage instruction |
| s2_rt | input | 5 | Second source register of the decode-stage instruction |
| br_taken | input | 1 | Branch taken; next PC is not sequential |
| s4_jump | input | 1 | Jump resolving in stage 4 |
| fwd_a_sel | output | 2 | Source select for ALU operand A |
| fwd_b_sel | output | 2 | Source select for ALU operand B |
| hold_fetch | output | 1 | Freeze the PC and the fetch/decode register |
| flush_o | output | 3 | Clear the stage 1..3 pipeline registers (bit 0 = stage 1) |

## Verification
The forwarding sweep covers every combination of the two write enables with addresses drawn from {0,1,2} for both destinations and both stage-3 sources. This patterns tells apart four cases:
- no match;
- a stage-4-only hit;
- a stage-5-only hit;
- a double hit, which must give code 1.

The zero address in the set separates a genuine hit from a write to register 0. A second sweep covers the memory-read flag, branch and jump against target and decode sources from the same set. It separates a load with no match from a load matching rs or rt, a non-load with a matching address, and a stall that coincides with a flush.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    FWD_NONE = 2'd0,
    FWD_MEM  = 2'd1,
    FWD_WB   = 2'd2
  } fwd_sel_e;

  // A producer hits a consumer source when it really writes a nonzero register
  // whose number equals the source number.
  function automatic logic dst_hits(input logic wen, input logic [4:0] dst,
                                    input logic [4:0] src);
    return wen && (dst != 5'd0) && (dst == src);
  endfunction

  // Nearer producer (stage 4) wins.
  function automatic fwd_sel_e pick_src(input logic hit_mem, input logic hit_wb);
    fwd_sel_e r;
    if (hit_mem)     r = FWD_MEM;
    else if (hit_wb) r = FWD_WB;
    else             r = FWD_NONE;
    return r;
  endfunction

  function automatic logic load_use(input logic memrd, input logic [4:0] tgt,
                                    input logic [4:0] use_a, input logic [4:0] use_b);
    return memrd && ((tgt == use_a) || (tgt == use_b));
  endfunction

endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel #(
  parameter int AW = 5
) (
  input  logic          mem_wen,
  input  logic [AW-1:0] mem_dst,
  input  logic          wb_wen,
  input  logic [AW-1:0] wb_dst,
  input  logic [AW-1:0] src,
  output logic          hit_mem,
  output logic          hit_wb,
  output logic [1:0]    sel
);
  import hz_pkg::*;

  always_comb begin
    hit_mem = dst_hits(mem_wen, mem_dst, src);
    hit_wb  = dst_hits(wb_wen, wb_dst, src);
    sel     = pick_src(hit_mem, hit_wb);
  end

endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int AW = 5
) (
  input  logic          memrd,
  input  logic [AW-1:0] tgt,
  input  logic [AW-1:0] use_rs,
  input  logic [AW-1:0] use_rt,
  output logic          raw_stall
);
  import hz_pkg::*;

  always_comb raw_stall = load_use(memrd, tgt, use_rs, use_rt);

endmodule

// File: rtl/hz_flush_gen.sv
module hz_flush_gen #(
  parameter int NSTG = 3
) (
  input  logic            br_taken,
  input  logic            late_jump,
  output logic            flush_any,
  output logic [NSTG-1:0] flush
);

  assign flush_any = br_taken | late_jump;

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    assign flush[g] = flush_any;
  end

endmodule

// File: rtl/hz_resolve_unit.sv
module hz_resolve_unit #(
  parameter int AW   = 5,
  parameter int NSTG = 3
) (
  input  logic            s4_wen,
  input  logic [AW-1:0]   s4_dst,
  input  logic            s5_wen,
  input  logic [AW-1:0]   s5_dst,
  input  logic [AW-1:0]   s3_rs,
  input  logic [AW-1:0]   s3_rt,
  input  logic            s3_memrd,
  input  logic [AW-1:0]   s2_rs,
  input  logic [AW-1:0]   s2_rt,
  input  logic            br_taken,
  input  logic            s4_jump,
  output logic [1:0]      fwd_a_sel,
  output logic [1:0]      fwd_b_sel,
  output logic            hold_fetch,
  output logic [NSTG-1:0] flush_o
);

  localparam int NOPS = 2;

  logic [AW-1:0] op_src  [NOPS];
  logic [1:0]    op_sel  [NOPS];
  logic          op_hit4 [NOPS];
  logic          op_hit5 [NOPS];
  logic          raw_stall;
  logic          flush_any;

  assign op_src[0] = s3_rs;
  assign op_src[1] = s3_rt;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    hz_fwd_sel #(.AW(AW)) u_sel (
      .mem_wen (s4_wen),
      .mem_dst (s4_dst),
      .wb_wen  (s5_wen),
      .wb_dst  (s5_dst),
      .src     (op_src[g]),
      .hit_mem (op_hit4[g]),
      .hit_wb  (op_hit5[g]),
      .sel     (op_sel[g])
    );
  end

  hz_load_use #(.AW(AW)) u_lu (
    .memrd     (s3_memrd),
    .tgt       (s3_rt),
    .use_rs    (s2_rs),
    .use_rt    (s2_rt),
    .raw_stall (raw_stall)
  );

  hz_flush_gen #(.NSTG(NSTG)) u_fl (
    .br_taken  (br_taken),
    .late_jump (s4_jump),
    .flush_any (flush_any),
    .flush     (flush_o)
  );

  assign fwd_a_sel  = op_sel[0];
  assign fwd_b_sel  = op_sel[1];
  // A squashed load must not keep the front end frozen.
  assign hold_fetch = raw_stall & ~flush_any;

endmodule

// File: rtl/hz_resolve_chk.sv
module hz_resolve_chk #(
  parameter int AW   = 5,
  parameter int NSTG = 3
) (
  input logic            s4_wen,
  input logic [AW-1:0]   s4_dst,
  input logic            s5_wen,
  input logic [AW-1:0]   s5_dst,
  input logic [AW-1:0]   s3_rs,
  input logic [AW-1:0]   s3_rt,
  input logic            s3_memrd,
  input logic [AW-1:0]   s2_rs,
  input logic [AW-1:0]   s2_rt,
  input logic            br_taken,
  input logic            s4_jump,
  input logic [1:0]      fwd_a_sel,
  input logic [1:0]      fwd_b_sel,
  input logic            hold_fetch,
  input logic [NSTG-1:0] flush_o,
  input logic            raw_stall
);

  always_comb begin
    p_code_range_r1: assert (fwd_a_sel != 2'd3 && fwd_b_sel != 2'd3);
    if (fwd_a_sel == 2'd1)
      p_a_mem_r2: assert (s4_wen && s4_dst == s3_rs && s4_dst != '0);
    if (fwd_a_sel == 2'd2)
      p_a_wb_r3: assert (s5_wen && s5_dst == s3_rs &&
                         !(s4_wen && s4_dst == s3_rs && s4_dst != '0));
    if (fwd_b_sel == 2'd2)
      p_b_wb_r4: assert (s5_wen && s5_dst == s3_rt &&
                         !(s4_wen && s4_dst == s3_rt && s4_dst != '0));
    if (fwd_a_sel != 2'd0)
      p_a_zero_r5: assert (fwd_a_sel == 2'd1 ? s4_dst != '0 : s5_dst != '0);
    if (hold_fetch)
      p_stall_cause_r6: assert (s3_memrd && (s3_rt == s2_rs || s3_rt == s2_rt));
    if (!s3_memrd)
      p_no_load_r7: assert (!hold_fetch && !raw_stall);
    p_flush_all_r8: assert (flush_o == '0 || flush_o == '1);
    p_flush_cause_r8: assert ((flush_o != '0) == (br_taken || s4_jump));
    p_flush_wins_r9: assert (!(hold_fetch && flush_o != '0));
  end

endmodule

bind hz_resolve_unit hz_resolve_chk #(.AW(AW), .NSTG(NSTG)) u_chk (
  .s4_wen     (s4_wen),
  .s4_dst     (s4_dst),
  .s5_wen     (s5_wen),
  .s5_dst     (s5_dst),
  .s3_rs      (s3_rs),
  .s3_rt      (s3_rt),
  .s3_memrd   (s3_memrd),
  .s2_rs      (s2_rs),
  .s2_rt      (s2_rt),
  .br_taken   (br_taken),
  .s4_jump    (s4_jump),
  .fwd_a_sel  (fwd_a_sel),
  .fwd_b_sel  (fwd_b_sel),
  .hold_fetch (hold_fetch),
  .flush_o    (flush_o),
  .raw_stall  (raw_stall)
);

// File: tb/hz_resolve_unit_tb.sv
module hz_resolve_unit_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       s4_wen, s5_wen, s3_memrd, br_taken, s4_jump;
  logic [4:0] s4_dst, s5_dst, s3_rs, s3_rt, s2_rs, s2_rt;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic       hold_fetch;
  logic [2:0] flush_o;

  hz_resolve_unit u_dut (
    .s4_wen(s4_wen), .s4_dst(s4_dst), .s5_wen(s5_wen), .s5_dst(s5_dst),
    .s3_rs(s3_rs), .s3_rt(s3_rt), .s3_memrd(s3_memrd),
    .s2_rs(s2_rs), .s2_rt(s2_rt), .br_taken(br_taken), .s4_jump(s4_jump),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
    .hold_fetch(hold_fetch), .flush_o(flush_o)
  );

  typedef struct {
    logic [1:0] a;
    logic [1:0] b;
    logic       st;
    logic [2:0] fl;
    string      tag_fwd;
    string      tag_ctl;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  // Independent model: code value from priority of producers.
  function automatic logic [1:0] model_sel(logic w4, logic [4:0] d4, logic w5,
                                           logic [4:0] d5, logic [4:0] s);
    logic [1:0] r = 2'd0;
    if (w5 && d5 == s && |d5) r = 2'd2;
    if (w4 && d4 == s && |d4) r = 2'd1;
    return r;
  endfunction

  function automatic string fwd_tag(logic [1:0] e, logic [4:0] d4, logic [4:0] d5);
    if (e == 2'd1) return "R2";
    if (e == 2'd2) return "R3";
    if (d4 == 5'd0 || d5 == 5'd0) return "R5";
    return "R1";
  endfunction

  task automatic drive(logic w4, logic [4:0] d4, logic w5, logic [4:0] d5,
                       logic [4:0] r3s, logic [4:0] r3t, logic mr,
                       logic [4:0] r2s, logic [4:0] r2t, logic br, logic jp);
    exp_t e;
    logic ls, fl;
    @(posedge clk);
    s4_wen = w4; s4_dst = d4; s5_wen = w5; s5_dst = d5;
    s3_rs = r3s; s3_rt = r3t; s3_memrd = mr; s2_rs = r2s; s2_rt = r2t;
    br_taken = br; s4_jump = jp;
    e.a = model_sel(w4, d4, w5, d5, r3s);
    e.b = model_sel(w4, d4, w5, d5, r3t);
    fl = br | jp;
    ls = mr & ((r3t == r2s) | (r3t == r2t));
    e.st = ls & ~fl;
    e.fl = fl ? 3'b111 : 3'b000;
    e.tag_fwd = fwd_tag(e.a, d4, d5);
    e.tag_ctl = (ls && fl) ? "R9" : (e.st ? "R6" : "R7");
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total += 4;
      if (fwd_a_sel !== e.a) begin
        bad++;
        $display("FAIL %s fwd_a_sel act=%0d exp=%0d", e.tag_fwd, fwd_a_sel, e.a);
      end
      if (fwd_b_sel !== e.b) begin
        bad++;
        $display("FAIL R4 fwd_b_sel act=%0d exp=%0d", fwd_b_sel, e.b);
      end
      if (hold_fetch !== e.st) begin
        bad++;
        $display("FAIL %s hold_fetch act=%0d exp=%0d", e.tag_ctl, hold_fetch, e.st);
      end
      if (flush_o !== e.fl) begin
        bad++;
        $display("FAIL R8 flush_o act=%b exp=%b", flush_o, e.fl);
      end
    end
  end

  initial begin
    s4_wen = 0; s5_wen = 0; s3_memrd = 0; br_taken = 0; s4_jump = 0;
    s4_dst = 0; s5_dst = 0; s3_rs = 0; s3_rt = 0; s2_rs = 0; s2_rt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state with quiet inputs (R1, R7, R8)
    total++;
    if (fwd_a_sel !== 2'd0 || fwd_b_sel !== 2'd0 || hold_fetch !== 1'b0 || flush_o !== 3'b0) begin
      bad++;
      $display("FAIL R1 reset outputs act=%0d/%0d/%0d/%b exp=0/0/0/000",
               fwd_a_sel, fwd_b_sel, hold_fetch, flush_o);
    end
    rst = 0;
    // Forwarding sweep: R1..R5, including double hits.
    for (int w = 0; w < 4; w++)
      for (int d4 = 0; d4 < 3; d4++)
        for (int d5 = 0; d5 < 3; d5++)
          for (int rs = 0; rs < 3; rs++)
            for (int rt = 0; rt < 3; rt++)
              drive(w[0], 5'(d4), w[1], 5'(d5), 5'(rs), 5'(rt), 1'b0,
                    5'd7, 5'd7, 1'b0, 1'b0);
    // Large addresses: full 5-bit compare (R2, R4)
    drive(1'b1, 5'd31, 1'b1, 5'd30, 5'd31, 5'd30, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0);
    drive(1'b1, 5'd15, 1'b0, 5'd31, 5'd31, 5'd15, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0);
    // Stall and flush sweep: R6..R9
    for (int c = 0; c < 8; c++)
      for (int t = 0; t < 3; t++)
        for (int a = 0; a < 3; a++)
          for (int b = 0; b < 3; b++)
            drive(1'b0, 5'd0, 1'b0, 5'd0, 5'd9, 5'(t), c[0],
                  5'(a), 5'(b), c[1], c[2]);
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule